// File: doc/BRIEF.md
# Configuration Shadow Register Refresher

This block keeps a bank of five configuration registers that mirror bytes held in a slow non-volatile store. The bank holds a control byte, an oscillator offset, a quadratic coefficient, a turnover value and a data byte. Right after reset the block fetches all five from the store. While the refresh enable bit in the shadowed control byte is set, it fetches them again on every hourly tick. Any corruption of the shadow copy is therefore repaired within an hour.

The store is reached through one request/acknowledge port that carries both reads and writes. A host reads the shadow values through a small index-addressed port. The host can also ask for one byte to be written to any store address, including the two application bytes at 0x28 and 0x29. A single busy output covers both the scrub and host writes to the store. The hourly tick comes from outside.

Top module: `cfg_shadow_refresh`

## Requirements
- R1: After reset the block reads store addresses CFG_BASE to CFG_BASE+4 (default 0x30 to 0x34). `cfg_ready` stays 0 until the last of those reads is acknowledged, then goes to 1 and stays there. No store write starts while `cfg_ready` is 0.
- R2: A reload makes exactly one read per register, in increasing address order: index 0 control, 1 offset, 2 quadratic coefficient, 3 turnover, 4 data. A shadow register changes only in the cycle after its own read acknowledge.
- R3: When bit 7 of the control shadow (refresh enable) is 1, an `hour_tick` pulse while idle starts a full reload. Afterwards every shadow register equals its store byte.
- R4: When refresh enable is 0, `hour_tick` has no effect: no store transaction is made and `busy` stays 0.
- R5: `busy` is 1 during reset, during the initial load, and from the cycle after a reload or store write begins until the cycle after its final acknowledge. It is 0 when idle.
- R6: A one-cycle `host_wr_valid` pulse makes one store write of `host_wr_data` at `host_wr_addr`. Any address is accepted, including 0x28 and 0x29. The write does not change any shadow register before the next reload.
- R7: A host write that arrives during a reload, including the initial load, is held. It is issued right after the last read of that reload and is never dropped.
- R8: An enabled `hour_tick` that arrives during a store write is held. A full reload starts right after the write acknowledge.
- R9: When `hour_tick` and `host_wr_valid` arrive in the same idle cycle, the write is made first and the reload follows.
- R10: An `hour_tick` that arrives during a reload is dropped, so no second reload follows.
- R11: A new refresh enable value takes effect only after the reload that loads it. The reload that brings in a 0 completes, and later ticks are then ignored.
- R12: `st_req` stays high with stable `st_addr` and `st_we` until `st_ack`. `st_wdata` stays stable as well during a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hour_tick | input | 1 | One-cycle hourly pulse |
| hst_rd_idx | input | 3 | Shadow register index to read (0 to 4) |
| hst_rd_data | output | 8 | Shadow value at hst_rd_idx (combinational) |
| host_wr_valid | input | 1 | One-cycle request to write the store |
| host_wr_addr | input | 6 | Store address for the host write |
| host_wr_data | input | 8 | Byte for the host write |
| busy | output | 1 | Store activity in progress or held |
| cfg_ready | output | 1 | Initial load has completed |
| st_req | output | 1 | Store transaction request |
| st_we | output | 1 | 1 = write, 0 = read |
| st_addr | output | 6 | Store address |
| st_wdata | output | 8 | Store write byte |
| st_ack | input | 1 | Store acknowledge, one cycle |
| st_rdata | input | 8 | Store read byte, valid with st_ack |

## Verification
The hourly scrub and a host store write can both be requested in the same cycle. The bench provokes this in three ways:
- It raises `hour_tick` and `host_wr_valid` together while the block is idle.
- It pulses the tick one cycle into a write.
- It issues a write a few cycles into a reload, and once during the initial load.

The behavioural store logs every acknowledged transaction with its kind and address. The bench judges each case from that log: it checks whether the write comes first or last, and that exactly five ordered reads surround it. It also checks that the written byte lands in the store.

// File: rtl/cfgsh_pkg.sv
// Shared types for the configuration shadow refresher.
package cfgsh_pkg;
    // Sequencer state: idle, reading a shadow register, or writing the store.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } cfgsh_state_e;
endpackage

// File: rtl/cfgsh_bank.sv
// Shadow register bank.
// Holds NREG bytes. Each byte is loaded only when the load strobe names
// its index. Offers a combinational read mux and exposes the refresh
// enable bit taken from register 0.
// Assumes ld_idx < NREG whenever ld_en is high.
module cfgsh_bank #(
    parameter int NREG   = 5,
    parameter int DW     = 8,
    parameter int IW     = 3,
    parameter int EN_BIT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_idx,
    input  logic [DW-1:0] ld_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic          ref_en
);
    logic [DW-1:0] sh [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] q;
        // Load this register only on its own read acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (ld_en && ld_idx == IW'(g))
                q <= ld_data;
        end
        assign sh[g] = q;
    end

    // Select the shadow byte named by the host index (0 when out of range).
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NREG; k++)
            if (rd_idx == IW'(k))
                rd_data = sh[k];
    end

    assign ref_en = sh[0][EN_BIT];
endmodule

// File: rtl/cfgsh_ctrl.sv
// Store access sequencer.
// Runs the initial load and hourly reloads as ordered single reads. It
// also issues host store writes. A write that arrives during a reload is
// held until the reload ends. An enabled tick that arrives during a write
// is held until the write ends. A tick during a reload is dropped.
// Assumes at most one host write is outstanding: the host issues no new
// write while one is held or in progress.
module cfgsh_ctrl
    import cfgsh_pkg::*;
#(
    parameter int          NREG     = 5,
    parameter int          AW       = 6,
    parameter int          DW       = 8,
    parameter int          IW       = 3,
    parameter logic [AW-1:0] CFG_BASE = 6'h30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hour_tick,
    input  logic          ref_en,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          st_ack,
    output logic          st_req,
    output logic          st_we,
    output logic [AW-1:0] st_addr,
    output logic [DW-1:0] st_wdata,
    output logic          ld_en,
    output logic [IW-1:0] ld_idx,
    output logic          busy,
    output logic          cfg_ready
);
    localparam logic [IW-1:0] LAST = IW'(NREG - 1);

    cfgsh_state_e  state;
    logic [IW-1:0] idx;
    logic          tick_pend;
    logic          wr_held;
    logic [AW-1:0] wa_q;
    logic [DW-1:0] wd_q;
    logic          held_n;
    logic          pend_n;

    assign held_n = wr_held | wr_valid;
    assign pend_n = tick_pend | (hour_tick & ref_en);

    // Advance the sequencer and capture host write requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_READ;
            idx       <= '0;
            cfg_ready <= 1'b0;
            tick_pend <= 1'b0;
            wr_held   <= 1'b0;
            wa_q      <= '0;
            wd_q      <= '0;
        end else begin
            if (wr_valid) begin
                wa_q <= wr_addr;
                wd_q <= wr_data;
            end
            case (state)
                ST_IDLE: begin
                    if (wr_valid) begin
                        state     <= ST_WRITE;
                        tick_pend <= hour_tick & ref_en;
                    end else if (hour_tick && ref_en) begin
                        state <= ST_READ;
                        idx   <= '0;
                    end
                end
                ST_READ: begin
                    if (st_ack && idx == LAST) begin
                        cfg_ready <= 1'b1;
                        wr_held   <= 1'b0;
                        state     <= held_n ? ST_WRITE : ST_IDLE;
                    end else begin
                        wr_held <= held_n;
                        if (st_ack)
                            idx <= idx + 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (st_ack) begin
                        tick_pend <= 1'b0;
                        idx       <= '0;
                        state     <= pend_n ? ST_READ : ST_IDLE;
                    end else begin
                        tick_pend <= pend_n;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the store port and the shadow load strobe from the state.
    always_comb begin
        st_req   = (state != ST_IDLE);
        st_we    = (state == ST_WRITE);
        st_addr  = st_we ? wa_q : CFG_BASE + AW'(idx);
        st_wdata = wd_q;
        ld_en    = (state == ST_READ) && st_ack;
        ld_idx   = idx;
        busy     = (state != ST_IDLE);
    end
endmodule

// File: rtl/cfg_shadow_refresh.sv
// Configuration shadow register refresher (top).
// Mirrors NREG configuration bytes from a non-volatile store into shadow
// registers. The load runs after reset and on each enabled hourly tick.
// Host store writes pass through the same store port.
// Assumes the store answers each request with a one-cycle acknowledge.
module cfg_shadow_refresh #(
    parameter int            NREG     = 5,
    parameter int            AW       = 6,
    parameter int            DW       = 8,
    parameter int            EN_BIT   = 7,
    parameter logic [AW-1:0] CFG_BASE = 6'h30,
    localparam int           IW       = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hour_tick,
    input  logic [IW-1:0] hst_rd_idx,
    output logic [DW-1:0] hst_rd_data,
    input  logic          host_wr_valid,
    input  logic [AW-1:0] host_wr_addr,
    input  logic [DW-1:0] host_wr_data,
    output logic          busy,
    output logic          cfg_ready,
    output logic          st_req,
    output logic          st_we,
    output logic [AW-1:0] st_addr,
    output logic [DW-1:0] st_wdata,
    input  logic          st_ack,
    input  logic [DW-1:0] st_rdata
);
    logic          ref_en;
    logic          ld_en;
    logic [IW-1:0] ld_idx;

    cfgsh_ctrl #(
        .NREG(NREG), .AW(AW), .DW(DW), .IW(IW), .CFG_BASE(CFG_BASE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .hour_tick(hour_tick), .ref_en(ref_en),
        .wr_valid(host_wr_valid), .wr_addr(host_wr_addr), .wr_data(host_wr_data),
        .st_ack(st_ack), .st_req(st_req), .st_we(st_we), .st_addr(st_addr),
        .st_wdata(st_wdata), .ld_en(ld_en), .ld_idx(ld_idx), .busy(busy),
        .cfg_ready(cfg_ready)
    );

    cfgsh_bank #(
        .NREG(NREG), .DW(DW), .IW(IW), .EN_BIT(EN_BIT)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
        .ld_data(st_rdata), .rd_idx(hst_rd_idx), .rd_data(hst_rd_data),
        .ref_en(ref_en)
    );
endmodule

// File: rtl/cfgsh_checker.sv
// Assertion checker for cfg_shadow_refresh, attached by bind below.
module cfgsh_checker #(
    parameter int            NREG     = 5,
    parameter int            AW       = 6,
    parameter int            DW       = 8,
    parameter int            IW       = 3,
    parameter logic [AW-1:0] CFG_BASE = 6'h30
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hour_tick,
    input logic          host_wr_valid,
    input logic          ref_en,
    input logic          busy,
    input logic          cfg_ready,
    input logic          st_req,
    input logic          st_we,
    input logic [AW-1:0] st_addr,
    input logic [DW-1:0] st_wdata,
    input logic          st_ack,
    input logic [IW-1:0] hst_rd_idx,
    input logic [DW-1:0] hst_rd_data
);
    // R12: request, address and direction are held until acknowledged.
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && !st_ack) |=> (st_req && $stable(st_addr) && $stable(st_we)));

    // R12: write data is held during an unacknowledged write.
    a_r12_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && st_we && !st_ack) |=> $stable(st_wdata));

    // R1: no store write before the initial load completes.
    a_r1_no_early_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ready |-> !(st_req && st_we));

    // R1: ready never drops once set.
    a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |=> cfg_ready);

    // R2: reads only target the shadowed address window.
    a_r2_read_window: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && !st_we) |-> (int'(st_addr) >= int'(CFG_BASE) &&
                                int'(st_addr) < int'(CFG_BASE) + NREG));

    // R2: the shadow value seen by the host changes only after a read ack.
    a_r2_update_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_req && !st_we && st_ack) |=>
            (!$stable(hst_rd_idx) || $stable(hst_rd_data)));

    // R4: a tick with refresh disabled leaves an idle block idle.
    a_r4_tick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && hour_tick && !host_wr_valid && !ref_en) |=> !busy);

    // R5: busy does not drop while a transaction awaits its ack.
    a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !st_ack) |=> busy);
endmodule

bind cfg_shadow_refresh cfgsh_checker #(
    .NREG(NREG), .AW(AW), .DW(DW), .IW(IW), .CFG_BASE(CFG_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hour_tick(hour_tick),
    .host_wr_valid(host_wr_valid), .ref_en(ref_en), .busy(busy),
    .cfg_ready(cfg_ready), .st_req(st_req), .st_we(st_we),
    .st_addr(st_addr), .st_wdata(st_wdata), .st_ack(st_ack),
    .hst_rd_idx(hst_rd_idx), .hst_rd_data(hst_rd_data)
);

// File: tb/tb_cfg_shadow_refresh.sv
// Self-checking bench: behavioural store with a transaction log,
// a vector table of host writes and reloads, then directed cases.
module tb_cfg_shadow_refresh;
    localparam int          NREG = 5;
    localparam logic [5:0]  BASE = 6'h30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hour_tick = 1'b0;
    logic [2:0] hst_rd_idx = '0;
    logic [7:0] hst_rd_data;
    logic       host_wr_valid = 1'b0;
    logic [5:0] host_wr_addr = '0;
    logic [7:0] host_wr_data = '0;
    logic       busy, cfg_ready, st_req, st_we;
    logic [5:0] st_addr;
    logic [7:0] st_wdata;
    logic       st_ack = 1'b0;
    logic [7:0] st_rdata = '0;

    int checks = 0;
    int failures = 0;

    logic [7:0] mem [64];
    logic [7:0] exp_sh [NREG];
    int         log_n = 0;
    logic       log_we [256];
    logic [5:0] log_addr [256];

    // Table of host writes: {address[13:8], data[7:0]}; control byte kept enabled.
    localparam logic [13:0] VEC [6] = '{
        {6'h31, 8'h5A}, {6'h32, 8'hC3}, {6'h28, 8'h11},
        {6'h29, 8'hEE}, {6'h33, 8'h7F}, {6'h34, 8'h01}
    };

    cfg_shadow_refresh dut (
        .clk(clk), .rst_n(rst_n), .hour_tick(hour_tick),
        .hst_rd_idx(hst_rd_idx), .hst_rd_data(hst_rd_data),
        .host_wr_valid(host_wr_valid), .host_wr_addr(host_wr_addr),
        .host_wr_data(host_wr_data), .busy(busy), .cfg_ready(cfg_ready),
        .st_req(st_req), .st_we(st_we), .st_addr(st_addr),
        .st_wdata(st_wdata), .st_ack(st_ack), .st_rdata(st_rdata)
    );

    always #5 clk = ~clk;

    // Behavioural store: acknowledges each request after one cycle and logs it.
    initial begin
        forever begin
            @(negedge clk);
            if (st_ack || !rst_n) begin
                st_ack = 1'b0;
            end else if (st_req === 1'b1) begin
                st_ack = 1'b1;
                if (st_we) mem[st_addr] = st_wdata;
                else       st_rdata = mem[st_addr];
                if (log_n < 256) begin
                    log_we[log_n]   = st_we;
                    log_addr[log_n] = st_addr;
                    log_n++;
                end
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        finish_run();
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr_valid = 1'b1; host_wr_addr = a; host_wr_data = d;
        @(negedge clk);
        host_wr_valid = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        hour_tick = 1'b1;
        @(negedge clk);
        hour_tick = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 1000, "R5 busy clears", n, 0);
    endtask

    task automatic rd_sh(input int i, output logic [7:0] v);
        @(negedge clk);
        hst_rd_idx = 3'(i);
        #1 v = hst_rd_data;
    endtask

    // Check five ordered reads starting at log entry s (R2).
    task automatic chk_reload(input int s, input string req);
        bit ok = (log_n >= s + NREG);
        for (int k = 0; k < NREG; k++)
            if (ok && (log_we[s+k] !== 1'b0 || log_addr[s+k] !== BASE + 6'(k))) ok = 0;
        chk(ok, req, log_n, s + NREG);
    endtask

    task automatic chk_shadow(input string req);
        logic [7:0] v;
        for (int i = 0; i < NREG; i++) begin
            rd_sh(i, v);
            chk(v === mem[BASE + 6'(i)], req, v, mem[BASE + 6'(i)]);
            exp_sh[i] = mem[BASE + 6'(i)];
        end
    endtask

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
        mem[BASE] = 8'h85;                     // bit 7 = refresh enable

        // Reset state and initial load, with a host write held across it (R1, R7).
        repeat (3) @(negedge clk);
        #1 chk(busy === 1'b1, "R5 busy in reset", busy, 1);
        rst_n = 1'b1;
        log_n = 0;
        @(negedge clk);
        chk(cfg_ready === 1'b0, "R1 not ready at start", cfg_ready, 0);
        host_write(6'h28, 8'hA5);
        chk(cfg_ready === 1'b0, "R1 not ready during load", cfg_ready, 0);
        wait_idle();
        chk(cfg_ready === 1'b1, "R1 ready after load", cfg_ready, 1);
        chk_reload(0, "R1 R2 initial ordered reads");
        chk(log_n == 6 && log_we[5] === 1'b1 && log_addr[5] === 6'h28,
            "R7 held write after load", log_n, 6);
        chk(mem[6'h28] === 8'hA5, "R6 app byte written", mem[6'h28], 8'hA5);
        chk_shadow("R1 shadow loaded");

        // Vector table: host write leaves shadow alone, tick reloads (R3, R6).
        for (int k = 0; k < 6; k++) begin
            logic [5:0] a;
            logic [7:0] d;
            a = VEC[k][13:8];
            d = VEC[k][7:0];
            host_write(a, d);
            chk(busy === 1'b1, "R5 busy during write", busy, 1);
            wait_idle();
            chk(mem[a] === d, "R6 store write", mem[a], d);
            if (a >= BASE && a < BASE + 6'(NREG)) begin
                rd_sh(int'(a - BASE), v);
                chk(v === exp_sh[a - BASE], "R6 shadow untouched", v, exp_sh[a - BASE]);
            end
            log_n = 0;
            tick();
            chk(busy === 1'b1, "R5 busy during reload", busy, 1);
            wait_idle();
            chk_reload(0, "R3 reload on tick");
            chk_shadow("R3 shadow after reload");
        end

        // Tick and write in the same idle cycle: write first (R9).
        log_n = 0;
        @(negedge clk);
        hour_tick = 1'b1; host_wr_valid = 1'b1;
        host_wr_addr = 6'h29; host_wr_data = 8'h3C;
        @(negedge clk);
        hour_tick = 1'b0; host_wr_valid = 1'b0;
        wait_idle();
        chk(log_we[0] === 1'b1 && log_addr[0] === 6'h29, "R9 write first", log_addr[0], 6'h29);
        chk_reload(1, "R9 reload follows");
        chk(log_n == 6, "R9 transaction count", log_n, 6);

        // Tick one cycle into a write is held (R8).
        log_n = 0;
        @(negedge clk);
        host_wr_valid = 1'b1; host_wr_addr = 6'h32; host_wr_data = 8'h99;
        @(negedge clk);
        host_wr_valid = 1'b0; hour_tick = 1'b1;
        @(negedge clk);
        hour_tick = 1'b0;
        wait_idle();
        chk(log_we[0] === 1'b1, "R8 write before held tick", log_we[0], 1);
        chk_reload(1, "R8 held tick reload");
        chk_shadow("R8 shadow after held tick");

        // Write during a reload is held until the reload ends (R7).
        log_n = 0;
        tick();
        @(negedge clk);
        host_write(6'h28, 8'h42);
        wait_idle();
        chk_reload(0, "R7 reload completes first");
        chk(log_n == 6 && log_we[5] === 1'b1 && log_addr[5] === 6'h28,
            "R7 write after reload", log_n, 6);
        chk(mem[6'h28] === 8'h42, "R7 write not dropped", mem[6'h28], 8'h42);

        // Tick during a reload is dropped (R10).
        log_n = 0;
        tick();
        @(negedge clk);
        hour_tick = 1'b1;
        @(negedge clk);
        hour_tick = 1'b0;
        wait_idle();
        repeat (10) @(negedge clk);
        chk(log_n == NREG, "R10 single reload", log_n, NREG);

        // Disable refresh via the store: applies after the reload that loads it (R11, R4).
        host_write(BASE, 8'h05);
        wait_idle();
        log_n = 0;
        tick();
        wait_idle();
        chk(log_n == NREG, "R11 loading reload completes", log_n, NREG);
        rd_sh(0, v);
        chk(v === 8'h05, "R11 control byte loaded", v, 8'h05);
        log_n = 0;
        tick();
        chk(busy === 1'b0, "R4 idle after tick when off", busy, 0);
        repeat (10) @(negedge clk);
        chk(log_n == 0, "R4 no store access when off", log_n, 0);

        finish_run();
    end
endmodule